// File: doc/BRIEF.md
# Serial EEPROM Client Address Front End

This block is the receive front end of a serial-bus EEPROM client. It watches already-synchronised SCL and SDA levels and finds bus Start and Stop conditions. It shifts in the first byte after each Start and compares it with a fixed device-type nibble and three strap inputs. It answers with an acknowledge on the ninth clock by pulling SDA low through an open-drain enable.

When a write-direction request matches, two more bytes follow. They carry a 15-bit word address, and the block acknowledges each of them. Once the second byte is in, the block updates the held word address and pulses a valid strobe.

When a read-direction request matches, the block does not collect any word address. It pulses a read-request strobe, and the word address it presents is the one it already holds. The data phase, the storage array and the write timing belong to later stages.

Top module: `eeprom_addr_front`

## Requirements
- R1: After reset, the SDA pull-down enable is off, both strobes are low, the held word address is 0 and the direction flag is 0.
- R2: Bits are sampled on SCL rising edges, MSB first. The first byte after a Start matches when its bits 7..4 are 1010 and its bits 3, 2 and 1 equal strap inputs 2, 1 and 0. A matching byte is acknowledged by holding SDA low while SCL is high on the ninth clock.
- R3: A non-matching first byte is not acknowledged. Later bytes are also not acknowledged, and no strobe fires, until the next Start.
- R4: A match with bit 0 = 1 (read) sets the direction flag to 1 and pulses the read-request strobe once. It leaves the held word address unchanged and skips the word-address phase, so a following byte is not acknowledged.
- R5: A match with bit 0 = 0 (write) clears the direction flag. The next two bytes are each acknowledged. The first byte supplies address bits 14..8 from its bits 6..0, and its bit 7 is ignored. The second byte supplies address bits 7..0.
- R6: Each completed two-byte word address produces exactly one address-valid pulse, and the held word address then shows the new value. The valid and read-request strobes are never high together.
- R7: A Start seen in any state, including a repeated Start in the middle of the word-address phase, restarts reception at the device byte. A partly received word address is discarded.
- R8: A Stop releases SDA and returns the block to idle, so bytes clocked after it without a new Start are not acknowledged.
- R9: The SDA pull-down is enabled only on an SCL falling edge and removed on the next SCL falling edge, so SDA never changes while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| strap_i | input | 3 | Pin-strapped address bits (strap 2..0 ↔ byte bits 3..1) |
| sda_oe_o | output | 1 | When high, SDA is pulled low (acknowledge) |
| word_addr_o | output | 15 | Held word address pointer |
| dir_read_o | output | 1 | 1 when the last matched request was a read |
| addr_valid_o | output | 1 | One-cycle pulse when a new word address is complete |
| rd_req_o | output | 1 | One-cycle pulse on a matched read request |

## Verification
Assertions check four things on every cycle:
- SDA changes only on SCL falling edges.
- SDA is released after a Stop, and the block stays silent while it ignores a transaction.
- The two strobes are mutually exclusive.
- The held address stays stable across a read request.

Only the bench's scenarios can show the rest: that the match decision follows the strap inputs, that the don't-care bit is discarded, that a repeated Start drops a half-received address, and that bytes after a Stop or a mismatch go unanswered.

// File: rtl/eeprom_front_pkg.sv
package eeprom_front_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WHI,
    ST_WHI_ACK,
    ST_WLO,
    ST_WLO_ACK,
    ST_HOLD,
    ST_IGNORE
  } front_state_t;
endpackage

// File: rtl/bus_line_events.sv
module bus_line_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o,
  output logic sda_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
      start_o <= 1'b0;
      stop_o  <= 1'b0;
      rise_o  <= 1'b0;
      fall_o  <= 1'b0;
      sda_o   <= 1'b1;
    end else begin
      scl_q   <= scl_i;
      sda_q   <= sda_i;
      // SDA edge while SCL stays high marks a bus condition
      start_o <= scl_q & scl_i & sda_q & ~sda_i;
      stop_o  <= scl_q & scl_i & ~sda_q & sda_i;
      rise_o  <= ~scl_q & scl_i;
      fall_o  <= scl_q & ~scl_i;
      sda_o   <= sda_i;
    end
  end
endmodule

// File: rtl/dev_addr_match.sv
module dev_addr_match #(
  parameter int TYPE_W  = 4,
  parameter int STRAP_W = 3,
  parameter logic [TYPE_W-1:0] TYPE_ID = 4'b1010,
  localparam int HDR_W = TYPE_W + STRAP_W
) (
  input  logic [HDR_W-1:0]   hdr_i,
  input  logic [STRAP_W-1:0] strap_i,
  output logic               hit_o
);
  logic [STRAP_W-1:0] bit_eq;

  genvar g;
  generate
    for (g = 0; g < STRAP_W; g++) begin : g_strap
      assign bit_eq[g] = (hdr_i[g] == strap_i[g]);
    end
  endgenerate

  assign hit_o = (hdr_i[HDR_W-1 -: TYPE_W] == TYPE_ID) && (&bit_eq);
endmodule

// File: rtl/addr_phase_fsm.sv
module addr_phase_fsm
  import eeprom_front_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int ADDR_W  = 15,
  parameter int TYPE_W  = 4,
  parameter int STRAP_W = 3,
  parameter logic [TYPE_W-1:0] TYPE_ID = 4'b1010,
  localparam int CNT_W = $clog2(BYTE_W + 1),
  localparam int HI_W  = ADDR_W - BYTE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               rise_i,
  input  logic               fall_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  output logic               sda_oe_o,
  output logic [ADDR_W-1:0]  word_addr_o,
  output logic               dir_read_o,
  output logic               addr_valid_o,
  output logic               rd_req_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  front_state_t        state;
  logic [CNT_W-1:0]    bit_cnt;
  logic [BYTE_W-1:0]   shreg;
  logic [HI_W-1:0]     hi_part;
  logic                hit;

  dev_addr_match #(
    .TYPE_W (TYPE_W),
    .STRAP_W(STRAP_W),
    .TYPE_ID(TYPE_ID)
  ) i_match (
    .hdr_i  (shreg[BYTE_W-1:1]),
    .strap_i(strap_i),
    .hit_o  (hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      bit_cnt      <= '0;
      shreg        <= '0;
      hi_part      <= '0;
      sda_oe_o     <= 1'b0;
      word_addr_o  <= '0;
      dir_read_o   <= 1'b0;
      addr_valid_o <= 1'b0;
      rd_req_o     <= 1'b0;
    end else begin
      addr_valid_o <= 1'b0;
      rd_req_o     <= 1'b0;
      if (start_i) begin
        state    <= ST_DEV;
        bit_cnt  <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        state    <= ST_IDLE;
        bit_cnt  <= '0;
        sda_oe_o <= 1'b0;
      end else begin
        case (state)
          ST_DEV, ST_WHI, ST_WLO: begin
            if (rise_i && bit_cnt < FULL) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_i};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (fall_i && bit_cnt == FULL) begin
              if (state == ST_DEV) begin
                if (hit) begin
                  sda_oe_o   <= 1'b1;
                  state      <= ST_DEV_ACK;
                  dir_read_o <= shreg[0];
                  rd_req_o   <= shreg[0];
                end else begin
                  state <= ST_IGNORE;
                end
              end else if (state == ST_WHI) begin
                hi_part  <= shreg[HI_W-1:0];
                sda_oe_o <= 1'b1;
                state    <= ST_WHI_ACK;
              end else begin
                word_addr_o  <= {hi_part, shreg};
                addr_valid_o <= 1'b1;
                sda_oe_o     <= 1'b1;
                state        <= ST_WLO_ACK;
              end
            end
          end
          ST_DEV_ACK, ST_WHI_ACK, ST_WLO_ACK: begin
            if (fall_i) begin
              sda_oe_o <= 1'b0;
              bit_cnt  <= '0;
              if (state == ST_DEV_ACK) state <= dir_read_o ? ST_HOLD : ST_WHI;
              else if (state == ST_WHI_ACK) state <= ST_WLO;
              else state <= ST_HOLD;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_oe_on_fall_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe_o) |-> $past(fall_i));
  assert_oe_off_on_fall_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(sda_oe_o) |-> $past(fall_i || start_i || stop_i));
  assert_release_on_stop_R8: assert property (@(posedge clk) disable iff (rst)
    stop_i && !start_i |=> !sda_oe_o && state == ST_IDLE);
  assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
    start_i |=> !sda_oe_o && !addr_valid_o && !rd_req_o);
  assert_quiet_ignore_R3: assert property (@(posedge clk) disable iff (rst)
    state == ST_IGNORE |-> !sda_oe_o && !addr_valid_o);
  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({addr_valid_o, rd_req_o}));
  assert_write_dir_R6: assert property (@(posedge clk) disable iff (rst)
    addr_valid_o |-> !dir_read_o);
  assert_addr_hold_R4: assert property (@(posedge clk) disable iff (rst)
    rd_req_o |-> $stable(word_addr_o) && dir_read_o);
endmodule

// File: rtl/eeprom_addr_front.sv
module eeprom_addr_front #(
  parameter int BYTE_W  = 8,
  parameter int ADDR_W  = 15,
  parameter int TYPE_W  = 4,
  parameter int STRAP_W = 3,
  parameter logic [TYPE_W-1:0] TYPE_ID = 4'b1010
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  output logic               sda_oe_o,
  output logic [ADDR_W-1:0]  word_addr_o,
  output logic               dir_read_o,
  output logic               addr_valid_o,
  output logic               rd_req_o
);
  logic start_evt, stop_evt, rise_evt, fall_evt, sda_bit;

  bus_line_events i_events (
    .clk    (clk),
    .rst    (rst),
    .scl_i  (scl_i),
    .sda_i  (sda_i),
    .start_o(start_evt),
    .stop_o (stop_evt),
    .rise_o (rise_evt),
    .fall_o (fall_evt),
    .sda_o  (sda_bit)
  );

  addr_phase_fsm #(
    .BYTE_W (BYTE_W),
    .ADDR_W (ADDR_W),
    .TYPE_W (TYPE_W),
    .STRAP_W(STRAP_W),
    .TYPE_ID(TYPE_ID)
  ) i_fsm (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_evt),
    .stop_i      (stop_evt),
    .rise_i      (rise_evt),
    .fall_i      (fall_evt),
    .sda_i       (sda_bit),
    .strap_i     (strap_i),
    .sda_oe_o    (sda_oe_o),
    .word_addr_o (word_addr_o),
    .dir_read_o  (dir_read_o),
    .addr_valid_o(addr_valid_o),
    .rd_req_o    (rd_req_o)
  );
endmodule

// File: tb/test_eeprom_addr_front.sv
module test_eeprom_addr_front;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scl = 1'b1;
  logic        host_sda = 1'b1;
  logic [2:0]  strap = 3'b000;
  logic        sda_oe;
  logic [14:0] word_addr;
  logic        dir_read, addr_valid, rd_req;
  wire         sda_line = host_sda & ~sda_oe;

  int n_tests = 0;
  int n_fail  = 0;
  int av_cnt  = 0;
  int rd_cnt  = 0;
  bit done    = 1'b0;
  logic [14:0] exp_addr = '0;

  always #2 clk = ~clk;

  eeprom_addr_front i_eeprom_addr_front (
    .clk         (clk),
    .rst         (rst),
    .scl_i       (scl),
    .sda_i       (sda_line),
    .strap_i     (strap),
    .sda_oe_o    (sda_oe),
    .word_addr_o (word_addr),
    .dir_read_o  (dir_read),
    .addr_valid_o(addr_valid),
    .rd_req_o    (rd_req)
  );

  always @(posedge clk) begin
    if (addr_valid) av_cnt++;
    if (rd_req) rd_cnt++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    host_sda = 1'b1; wclk(4);
    scl = 1'b1; wclk(4);
    host_sda = 1'b0; wclk(4);
    scl = 1'b0; wclk(4);
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; wclk(4);
    scl = 1'b1; wclk(4);
    host_sda = 1'b1; wclk(4);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      host_sda = b[i]; wclk(4);
      scl = 1'b1; wclk(8);
      scl = 1'b0;
    end
    host_sda = 1'b1; wclk(4);
    scl = 1'b1; wclk(4);
    acked = (sda_line == 1'b0);
    wclk(4);
    scl = 1'b0; wclk(4);
  endtask

  function automatic logic [7:0] dev_byte(input logic [2:0] s, input bit rd);
    return {4'b1010, s, rd};
  endfunction

  // write transaction with expected results; returns nothing, updates exp_addr
  task automatic do_write(input logic [14:0] a, input bit top, input string req);
    bit ack0, ack1, ack2;
    int av0;
    av0 = av_cnt;
    bus_start();
    send_byte(dev_byte(strap, 1'b0), ack0);
    send_byte({top, a[14:8]}, ack1);
    send_byte(a[7:0], ack2);
    bus_stop();
    exp_addr = a;
    chk(ack0, "R2", ack0, 1);
    chk(ack1 && ack2, req, {ack1, ack2}, 2'b11);
    chk(word_addr == exp_addr, req, word_addr, exp_addr);
    chk(av_cnt == av0 + 1, "R6", av_cnt - av0, 1);
    chk(dir_read == 1'b0, "R5", dir_read, 0);
  endtask

  initial begin
    bit a0, a1, a2;
    int av0, rd0;
    logic [7:0] db;
    void'($urandom(32'h5eed_2c01));
    wclk(5);
    // R1 reset state
    chk(sda_oe == 1'b0, "R1", sda_oe, 0);
    chk(addr_valid == 1'b0 && rd_req == 1'b0, "R1", {addr_valid, rd_req}, 0);
    chk(word_addr == 15'd0, "R1", word_addr, 0);
    chk(dir_read == 1'b0, "R1", dir_read, 0);
    rst = 1'b0;
    wclk(4);

    // directed: strap extremes and the don't-care bit 7
    strap = 3'b111;
    do_write(15'h7fff, 1'b1, "R5");
    strap = 3'b000;
    do_write(15'h0123, 1'b1, "R5");

    // random mix of write, read and mismatched headers
    for (int it = 0; it < 45; it++) begin
      int kind;
      strap = 3'($urandom);
      kind  = int'($urandom % 3);
      if (kind == 0) begin
        do_write(15'($urandom), 1'($urandom), "R5");
      end else if (kind == 1) begin
        av0 = av_cnt; rd0 = rd_cnt;
        bus_start();
        send_byte(dev_byte(strap, 1'b1), a0);
        send_byte(8'($urandom), a1);
        bus_stop();
        chk(a0, "R2", a0, 1);
        chk(!a1, "R4", a1, 0);
        chk(rd_cnt == rd0 + 1 && av_cnt == av0, "R4", rd_cnt - rd0, 1);
        chk(word_addr == exp_addr, "R4", word_addr, exp_addr);
        chk(dir_read == 1'b1, "R4", dir_read, 1);
      end else begin
        int fb;
        fb = 1 + int'($urandom % 7);
        db = dev_byte(strap, 1'($urandom));
        db[fb] = ~db[fb];
        av0 = av_cnt; rd0 = rd_cnt;
        bus_start();
        send_byte(db, a0);
        send_byte(8'($urandom), a1);
        send_byte(8'($urandom), a2);
        bus_stop();
        chk(!a0 && !a1 && !a2, "R3", {a0, a1, a2}, 0);
        chk(av_cnt == av0 && rd_cnt == rd0, "R3", av_cnt - av0 + rd_cnt - rd0, 0);
        chk(word_addr == exp_addr, "R3", word_addr, exp_addr);
      end
    end

    // R7: repeated start after the first word-address byte
    strap = 3'b101;
    av0 = av_cnt;
    bus_start();
    send_byte(dev_byte(strap, 1'b0), a0);
    send_byte(8'h55, a1);
    bus_start();
    send_byte(dev_byte(strap, 1'b0), a0);
    send_byte(8'h0a, a1);
    send_byte(8'hbc, a2);
    bus_stop();
    exp_addr = 15'h0abc;
    chk(a0 && a1 && a2, "R7", {a0, a1, a2}, 3'b111);
    chk(word_addr == exp_addr, "R7", word_addr, exp_addr);
    chk(av_cnt == av0 + 1, "R7", av_cnt - av0, 1);

    // R7: repeated start turning a write into a read
    rd0 = rd_cnt;
    bus_start();
    send_byte(dev_byte(strap, 1'b0), a0);
    bus_start();
    send_byte(dev_byte(strap, 1'b1), a1);
    bus_stop();
    chk(a0 && a1 && rd_cnt == rd0 + 1, "R7", rd_cnt - rd0, 1);
    chk(word_addr == exp_addr, "R7", word_addr, exp_addr);

    // R8: bytes after a stop without a new start are ignored
    av0 = av_cnt;
    bus_start();
    send_byte(dev_byte(strap, 1'b0), a0);
    bus_stop();
    scl = 1'b0; wclk(4);
    send_byte(dev_byte(strap, 1'b0), a1);
    send_byte(8'h11, a2);
    chk(a0, "R2", a0, 1);
    chk(!a1 && !a2, "R8", {a1, a2}, 0);
    chk(sda_oe == 1'b0 && av_cnt == av0, "R8", sda_oe, 0);
    bus_stop();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule